// File: doc/BRIEF.md
# Dual-Channel Serial Port Interrupt Collector

This block gathers interrupt events from two serial-port channels and from three device-wide sources (wake-up, timer/counter, general-purpose pin events). It presents them to a host as one read-only 32-bit interrupt word. Each channel has a summary bit and a 3-bit code. The code names the most urgent source still waiting on that channel. Device-wide sources only ever appear in channel 0's code.

Every source arrives as a one-cycle event pulse and is held in a per-channel pending set until the host services it. The host services a channel by reading that channel's own status register. Outside logic turns that read into a one-cycle clear strobe for the channel. The strobe retires only the source the code is showing at that moment. Any other pending sources stay held, and the code moves on to the next one. All pins are plain level or pulse signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Event input bit k of a channel raises the source whose code is k. Bit 0 is wake-up and bit 5 is unused.

Top module: `uart_irq_agg`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge empties every pending set, so the interrupt word reads 0 after that edge.
- R2: Word bits [7:2] and [31:14] always read 0.
- R3: Word bit c (c = 0 for channel 0, 1 for channel 1) is 1 exactly while channel c has at least one pending source.
- R4: Channel 0's code sits in word bits [10:8] and channel 1's code in bits [13:11]. Each code gives the highest-priority pending source. Code 1 (receive data ready or line-status error) ranks first, then 2 (receive time-out), 3 (transmit ready/empty), 4 (modem-status change or flow/special character), 6 (general-purpose pin event) and 7 (timer/counter). Code 5 is never produced.
- R5: A pending wake-up (channel 0 event bit 0) sets channel 0's summary bit while the code reads 000. Wake-up ranks below every other channel 0 source.
- R6: Event bits 0, 6 and 7 of channel 1 have no effect, and event bit 5 of either channel has no effect.
- R7: A clear strobe on a channel removes only the source its code shows in that cycle. From the next cycle the code shows the next-highest remaining source, and the summary bit stays 1 if any source remains.
- R8: An event that arrives in the same cycle as a clear strobe on its channel ends up pending afterwards, even when it is the source being cleared.
- R9: An event presented at a clock edge is reflected in the word immediately after that edge.
- R10: The two channels hold, clear and encode their sources independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt_i | input | 16 | Event pulses; bits [8c+7:8c] belong to channel c, bit k raising source code k |
| clr_i | input | 2 | Per-channel clear strobe, driven from the host's read of that channel's status |
| irq_word_o | output | 32 | Interrupt word: summary bits [1:0], codes [10:8] and [13:11] |

## Verification
A clear strobe and a new event can fall on the same channel in the same cycle. In that case the retiring of the shown source and the arrival of the new one must both take effect. The bench provokes this in two ways. First, it re-raises the very source being cleared. Second, it raises a higher-ranked source during a clear. It judges each case by the code seen on the next cycle. A randomized phase then drives events and strobes freely on both channels. Every cycle is compared against a behavioural model of the pending sets, so these collisions also occur in mixed patterns.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int CODE_W   = 3;
  localparam int SRC_W    = 1 << CODE_W;
  // event bits honoured per channel kind (bit index = code value)
  localparam logic [SRC_W-1:0] DEV_CH_MASK   = 8'b1101_1111; // channel 0: all but unused code
  localparam logic [SRC_W-1:0] PLAIN_CH_MASK = 8'b0001_1110; // other channels: codes 1..4
  localparam int WAKE_BIT = 0;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [SRC_W-1:0]  pend,
  output logic [CODE_W-1:0] code,
  output logic [SRC_W-1:0]  sel,
  output logic              any
);
  logic found;
  always_comb begin
    code  = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 1; i < SRC_W; i++) begin
      if (pend[i] && !found) begin
        code   = CODE_W'(i);
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found && pend[WAKE_BIT]) sel[WAKE_BIT] = 1'b1;
    any = |pend;
  end
endmodule

// File: rtl/irq_src_pending.sv
module irq_src_pending
  import uart_irq_pkg::*;
#(
  parameter logic [SRC_W-1:0] MASK = PLAIN_CH_MASK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] evt,
  input  logic             clr,
  input  logic [SRC_W-1:0] shown,
  output logic [SRC_W-1:0] pend
);
  logic [SRC_W-1:0] retire;
  logic [SRC_W-1:0] pend_n;

  always_comb begin
    retire = clr ? shown : '0;
    // new events are applied after the retire so a colliding event survives
    pend_n = (pend & ~retire) | (evt & MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend_n;
  end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int WORD_W = 32,
  parameter int SUM_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH*SRC_W-1:0]   src_evt_i,
  input  logic [NCH-1:0]         clr_i,
  output logic [WORD_W-1:0]      irq_word_o
);
  localparam int CODE_LSB = SUM_W;

  logic [NCH-1:0][SRC_W-1:0]  pend;
  logic [NCH-1:0][SRC_W-1:0]  sel;
  logic [NCH-1:0][CODE_W-1:0] code;
  logic [NCH-1:0]             any;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [SRC_W-1:0] M = (c == 0) ? DEV_CH_MASK : PLAIN_CH_MASK;
    irq_src_pending #(.MASK(M)) u_pend (
      .clk   (clk),
      .rst   (rst),
      .evt   (src_evt_i[c*SRC_W +: SRC_W]),
      .clr   (clr_i[c]),
      .shown (sel[c]),
      .pend  (pend[c])
    );
    irq_prio_enc u_enc (
      .pend (pend[c]),
      .code (code[c]),
      .sel  (sel[c]),
      .any  (any[c])
    );
  end

  always_comb begin
    irq_word_o = '0;
    for (int c = 0; c < NCH; c++) begin
      irq_word_o[c] = any[c];
      irq_word_o[CODE_LSB + c*CODE_W +: CODE_W] = code[c];
    end
  end
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
  import uart_irq_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH*SRC_W-1:0] src_evt_i,
  input logic [NCH-1:0]       clr_i,
  input logic [31:0]          irq_word_o
);
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> irq_word_o == 32'd0);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_word_o[7:2] == 6'd0) && (irq_word_o[31:14] == 18'd0));

  for (genvar c = 0; c < NCH; c++) begin : g_ck
    localparam logic [SRC_W-1:0] M = (c == 0) ? DEV_CH_MASK : PLAIN_CH_MASK;

    p_code_implies_summary_r3: assert property (@(posedge clk) disable iff (rst)
      (irq_word_o[8+3*c +: 3] != 3'd0) |-> irq_word_o[c]);

    p_no_unused_code_r4: assert property (@(posedge clk) disable iff (rst)
      irq_word_o[8+3*c +: 3] != 3'd5);

    p_event_visible_r9: assert property (@(posedge clk) disable iff (rst)
      (|(src_evt_i[c*SRC_W +: SRC_W] & M)) |=> irq_word_o[c]);

    p_clear_moves_on_r7: assert property (@(posedge clk) disable iff (rst)
      (clr_i[c] && (src_evt_i[c*SRC_W +: SRC_W] == '0) && (irq_word_o[8+3*c +: 3] != 3'd0))
      |=> irq_word_o[8+3*c +: 3] != $past(irq_word_o[8+3*c +: 3]));
  end

  if (NCH > 1) begin : g_ch1
    p_no_device_src_ch1_r6: assert property (@(posedge clk) disable iff (rst)
      irq_word_o[13:11] < 3'd5);
  end
endmodule

bind uart_irq_agg uart_irq_agg_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .src_evt_i(src_evt_i), .clr_i(clr_i), .irq_word_o(irq_word_o)
);

// File: tb/uart_irq_agg_test.sv
module uart_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_evt_i = '0;
  logic [1:0]  clr_i = '0;
  logic [31:0] irq_word_o;

  int checks = 0;
  int errors = 0;
  bit pend [2][8];

  always #5 clk = ~clk;

  uart_irq_agg uut (.clk(clk), .rst(rst), .src_evt_i(src_evt_i), .clr_i(clr_i), .irq_word_o(irq_word_o));

  function automatic int shown_src(int c);
    for (int k = 1; k < 8; k++) if (pend[c][k]) return k;
    if (pend[c][0]) return 0;
    return -1;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int c = 0; c < 2; c++) begin
      int s = shown_src(c);
      w[c] = (s >= 0);
      if (s > 0) w[8+3*c +: 3] = 3'(s);
    end
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, clock, update model, compare away from the edge
  task automatic cyc(string req, logic [15:0] e, logic [1:0] c, logic r);
    src_evt_i = e; clr_i = c; rst = r;
    @(posedge clk);
    if (r) begin
      for (int ch = 0; ch < 2; ch++) for (int k = 0; k < 8; k++) pend[ch][k] = 0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        int s = shown_src(ch);
        if (c[ch] && s >= 0) pend[ch][s] = 0;
        for (int k = 0; k < 8; k++) begin
          bit ok = (k != 5) && (ch == 0 || (k >= 1 && k <= 4));
          if (ok && e[ch*8+k]) pend[ch][k] = 1;
        end
      end
    end
    @(negedge clk);
    check(req, irq_word_o, exp_word());
    checks++;
    if (irq_word_o[7:2] !== 6'd0 || irq_word_o[31:14] !== 18'd0) begin
      errors++;
      $display("FAIL R2: actual=%h expected reserved bits zero", irq_word_o);
    end
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc("R1", 16'h0000, 2'b00, 1'b1);
    check("R1", irq_word_o, 32'd0);
    cyc("R9", 16'h0008, 2'b00, 1'b0);          // ch0 transmit
    check("R4", irq_word_o, 32'h0000_0301);
    cyc("R4", 16'h0002, 2'b00, 1'b0);          // ch0 receive outranks
    check("R4", irq_word_o, 32'h0000_0101);
    cyc("R7", 16'h0000, 2'b01, 1'b0);          // retire receive only
    check("R7", irq_word_o, 32'h0000_0301);
    cyc("R7", 16'h0000, 2'b01, 1'b0);
    check("R3", irq_word_o, 32'd0);
    cyc("R5", 16'h0001, 2'b00, 1'b0);          // wake-up alone
    check("R5", irq_word_o, 32'h0000_0001);
    cyc("R5", 16'h0080, 2'b00, 1'b0);          // timer outranks wake
    check("R5", irq_word_o, 32'h0000_0701);
    cyc("R5", 16'h0000, 2'b01, 1'b0);
    check("R5", irq_word_o, 32'h0000_0001);
    cyc("R5", 16'h0000, 2'b01, 1'b0);
    check("R5", irq_word_o, 32'd0);
    cyc("R6", 16'hE100, 2'b00, 1'b0);          // ch1 device bits, unused bit
    check("R6", irq_word_o, 32'd0);
    cyc("R6", 16'h0020, 2'b00, 1'b0);          // ch0 unused bit
    check("R6", irq_word_o, 32'd0);
    cyc("R10", 16'h0410, 2'b00, 1'b0);         // ch1 timeout, ch0 modem
    check("R10", irq_word_o, 32'h0000_1403);
    cyc("R10", 16'h0000, 2'b01, 1'b0);
    check("R10", irq_word_o, 32'h0000_1002);
    cyc("R8", 16'h0400, 2'b10, 1'b0);          // re-raise source being cleared
    check("R8", irq_word_o, 32'h0000_1002);
    cyc("R8", 16'h1000, 2'b10, 1'b0);          // clear 2, new 4 arrives
    check("R8", irq_word_o, 32'h0000_2002);
    cyc("R8", 16'h0200, 2'b10, 1'b0);          // clear 4, higher 1 arrives
    check("R8", irq_word_o, 32'h0000_0802);
    for (int n = 0; n < 400; n++) begin
      logic [15:0] e;
      logic [1:0]  c;
      e = 16'($urandom) & 16'($urandom);
      c = 2'($urandom);
      cyc("R4", e, c, ($urandom % 97) == 0);
    end
    cyc("R1", 16'hFFFF, 2'b00, 1'b1);
    check("R1", irq_word_o, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule